// File: doc/BRIEF.md
# Biphase-Mark Two-Channel Audio Line Transmitter

This block turns a stream of 24-bit audio samples into a single biphase-mark coded line bit for a two-channel professional digital audio link. Time is counted in half bit cells: a one-cycle strobe `half_tick` from the surrounding clocking logic advances the line by one half-cell. Each subframe lasts 32 bit cells (64 half-cells). It starts with a synchronising preamble that breaks the biphase-mark rule on purpose. The 24 sample bits follow, least significant first. The subframe ends with validity, user, channel-status and parity slots. Subframes alternate between channel A and channel B. A block is a run of `BLOCK_LEN` subframes, and its first subframe carries the block-start preamble.

Samples enter through a valid/ready handshake. The port opens only during the preamble of each subframe, and the sample taken there fills that subframe. If no sample arrives while the port is open, the subframe carries an all-zero payload. The controller is a three-phase state machine with the states PREAMBLE, AUDIO and AUX. It runs PREAMBLE→AUDIO on the tick that emits half-cell 7, AUDIO→AUX on the tick that emits half-cell 55, and AUX→PREAMBLE on the tick that emits half-cell 63. Synchronous reset puts it in PREAMBLE at half-cell 0 of a block-start subframe.

Top module: `bmc_tx`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `line_out` = 0 and `smp_ready` = 1. The next subframe sent is the first of a block (block-start preamble), and its first tick inverts the line.
- R2: `line_out` changes only at clock edges where `half_tick` is high. Each such edge emits exactly one half-cell.
- R3: In half-cells 8 to 63, the line inverts at the start of every bit cell (even half-cell index). It inverts in the middle of the cell (odd index) only when that slot's bit is 1.
- R4: Within half-cells 0 to 7 of a subframe, the line inverts only at these indices: block-start preamble {0,3,4,5} (runs 3,1,1,3 half-cells); channel-B preamble {0,3,5,6} (runs 3,2,1,2); channel-A preamble {0,3,6,7} (runs 3,3,1,1).
- R5: Slots 4 to 27 carry sample bits 0 to 23, LSB first. Slot 28 carries the validity bit, slot 29 the user bit and slot 30 the channel-status bit, all latched with the sample. Slot 31 is a parity bit that makes the number of ones in slots 4 to 31 even.
- R6: Subframe 0 of a block uses the block-start preamble. Odd subframes use the channel-B preamble and the other even subframes use the channel-A preamble. After `BLOCK_LEN` (default 192) subframes, the count returns to subframe 0.
- R7: `smp_ready` rises on the tick that emits half-cell 63, and also on reset. It stays high until a transfer or until the tick that emits half-cell 7, whichever comes first. It is never high outside the preamble.
- R8: A subframe whose port closed without a transfer sends zero for all 24 sample bits, zero validity, user and status bits, and a zero parity bit.
- R9: A transfer (`smp_valid` and `smp_ready` both high at an edge) drops `smp_ready` in the next cycle. `smp_valid` asserted while `smp_ready` is low has no effect on the transmitted subframe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle strobe, once per half bit cell |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Sample port open (preamble window) |
| smp_data | input | SAMPLE_W | Audio sample, two's complement |
| smp_vbit | input | 1 | Validity bit for the offered sample |
| smp_ubit | input | 1 | User bit for the offered sample |
| smp_cbit | input | 1 | Channel-status bit for the offered sample |
| line_out | output | 1 | Biphase-mark coded line bit |

## Verification
If the half-cell counter or the phase state is wrong, the transition pattern at `line_out` breaks within one bit cell. A preamble lands on the wrong indices, or a cell-start inversion goes missing. A wrong subframe counter shows up as the wrong preamble in the very next subframe, and a missing wrap shows up one block later. The bench checks the line level after every tick against a level model built from the requirements. Any single wrong slot, whether an ordering, parity or latching fault, therefore shows as a mismatch in that half-cell. Handshake faults show within one cycle of the edge that opens, uses or closes the sample port.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

    // Fixed framing around the sample field (bit cells)
    localparam int PRE_SLOTS = 4;
    localparam int AUX_SLOTS = 4;

    typedef enum logic [1:0] {
        PH_PREAMBLE = 2'd0,
        PH_AUDIO    = 2'd1,
        PH_AUX      = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        PRE_CH_A  = 2'd0,
        PRE_CH_B  = 2'd1,
        PRE_BLOCK = 2'd2
    } pre_e;

    // Half-cell indices (0..7) of a preamble at which the line inverts
    function automatic logic [7:0] pre_toggle_mask(input pre_e kind);
        logic [7:0] m;
        unique case (kind)
            PRE_BLOCK: m = 8'b0011_1001;
            PRE_CH_B:  m = 8'b0110_1001;
            PRE_CH_A:  m = 8'b1100_1001;
            default:   m = 8'b1100_1001;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bmc_seq.sv
// Subframe sequencer: phase state machine, half-cell and subframe counters
module bmc_seq
    import bmc_pkg::*;
#(
    parameter  int SAMPLE_W  = 24,
    parameter  int BLOCK_LEN = 192,
    localparam int HALVES    = 2 * (PRE_SLOTS + SAMPLE_W + AUX_SLOTS),
    localparam int HALF_W    = $clog2(HALVES),
    localparam int SF_W      = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    output logic [HALF_W-1:0] half_idx,
    output phase_e            phase,
    output pre_e              pre_kind,
    output logic              sf_end,
    output logic              pre_last
);

    localparam logic [HALF_W-1:0] LAST_PRE  = HALF_W'(2 * PRE_SLOTS - 1);
    localparam logic [HALF_W-1:0] LAST_AUD  = HALF_W'(2 * (PRE_SLOTS + SAMPLE_W) - 1);
    localparam logic [HALF_W-1:0] LAST_HALF = HALF_W'(HALVES - 1);
    localparam logic [SF_W-1:0]   LAST_SF   = SF_W'(BLOCK_LEN - 1);

    phase_e            state_q, state_nx;
    logic [HALF_W-1:0] half_q;
    logic [SF_W-1:0]   sf_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_PREAMBLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            PH_PREAMBLE: if (half_tick && half_q == LAST_PRE)  state_nx = PH_AUDIO;
            PH_AUDIO:    if (half_tick && half_q == LAST_AUD)  state_nx = PH_AUX;
            PH_AUX:      if (half_tick && half_q == LAST_HALF) state_nx = PH_PREAMBLE;
            default:     state_nx = PH_PREAMBLE;
        endcase
    end

    // Half-cell index of the next half-cell to emit, and subframe position
    always_ff @(posedge clk) begin
        if (rst) begin
            half_q <= '0;
            sf_q   <= '0;
        end else if (half_tick) begin
            if (half_q == LAST_HALF) begin
                half_q <= '0;
                sf_q   <= (sf_q == LAST_SF) ? '0 : sf_q + 1'b1;
            end else begin
                half_q <= half_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        half_idx = half_q;
        phase    = state_q;
        sf_end   = (state_q == PH_AUX) && half_tick && (half_q == LAST_HALF);
        pre_last = (state_q == PH_PREAMBLE) && half_tick && (half_q == LAST_PRE);
        if (sf_q == '0) begin
            pre_kind = PRE_BLOCK;
        end else if (sf_q[0]) begin
            pre_kind = PRE_CH_B;
        end else begin
            pre_kind = PRE_CH_A;
        end
    end

endmodule

// File: rtl/bmc_slot_reg.sv
// Sample port: handshake window and the latched subframe payload word
module bmc_slot_reg #(
    parameter  int SAMPLE_W = 24,
    localparam int WORD_W   = SAMPLE_W + 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sf_end,
    input  logic                pre_last,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_vbit,
    input  logic                smp_ubit,
    input  logic                smp_cbit,
    output logic                smp_ready,
    output logic [WORD_W-1:0]   word
);

    logic open_q;
    logic take;
    logic par;

    assign take      = smp_valid && open_q;
    assign par       = ^{smp_cbit, smp_ubit, smp_vbit, smp_data};
    assign smp_ready = open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b1;
        end else if (sf_end) begin
            open_q <= 1'b1;
        end else if (take || pre_last) begin
            open_q <= 1'b0;
        end
    end

    // Payload order from LSB: sample, validity, user, status, parity
    always_ff @(posedge clk) begin
        if (rst || sf_end) begin
            word <= '0;
        end else if (take) begin
            word <= {par, smp_cbit, smp_ubit, smp_vbit, smp_data};
        end
    end

endmodule

// File: rtl/bmc_line_enc.sv
// Line encoder: decides per half-cell whether to invert, holds the line level
module bmc_line_enc
    import bmc_pkg::*;
#(
    parameter  int SAMPLE_W = 24,
    localparam int WORD_W   = SAMPLE_W + 4,
    localparam int HALVES   = 2 * (PRE_SLOTS + SAMPLE_W + AUX_SLOTS),
    localparam int HALF_W   = $clog2(HALVES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic [HALF_W-1:0] half_idx,
    input  phase_e            phase,
    input  pre_e              pre_kind,
    input  logic [WORD_W-1:0] word,
    output logic              line_out
);

    logic [HALF_W-1:0] slot_rel;
    logic [7:0]        pmask;
    logic              data_bit;
    logic              flip;

    always_comb begin
        slot_rel = (half_idx >> 1) - HALF_W'(PRE_SLOTS);
        pmask    = pre_toggle_mask(pre_kind);
        data_bit = |(word & (WORD_W'(1) << slot_rel));
        unique case (phase)
            PH_PREAMBLE: flip = pmask[half_idx[2:0]];
            PH_AUDIO,
            PH_AUX:      flip = half_idx[0] ? data_bit : 1'b1;
            default:     flip = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_out <= 1'b0;
        end else if (half_tick) begin
            line_out <= line_out ^ flip;
        end
    end

endmodule

// File: rtl/bmc_tx.sv
// Biphase-mark two-channel audio line transmitter, top level
module bmc_tx
    import bmc_pkg::*;
#(
    parameter  int SAMPLE_W  = 24,
    parameter  int BLOCK_LEN = 192,
    localparam int WORD_W    = SAMPLE_W + 4,
    localparam int HALVES    = 2 * (PRE_SLOTS + SAMPLE_W + AUX_SLOTS),
    localparam int HALF_W    = $clog2(HALVES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                half_tick,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                smp_vbit,
    input  logic                smp_ubit,
    input  logic                smp_cbit,
    output logic                line_out
);

    logic [HALF_W-1:0] half_idx;
    phase_e            phase;
    pre_e              pre_kind;
    logic              sf_end;
    logic              pre_last;
    logic [WORD_W-1:0] word;
    logic              half_zero;
    logic              half_lsb;

    assign half_zero = (half_idx == '0);
    assign half_lsb  = half_idx[0];

    bmc_seq #(
        .SAMPLE_W (SAMPLE_W),
        .BLOCK_LEN(BLOCK_LEN)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .half_tick(half_tick),
        .half_idx (half_idx),
        .phase    (phase),
        .pre_kind (pre_kind),
        .sf_end   (sf_end),
        .pre_last (pre_last)
    );

    bmc_slot_reg #(
        .SAMPLE_W(SAMPLE_W)
    ) slot_i (
        .clk      (clk),
        .rst      (rst),
        .sf_end   (sf_end),
        .pre_last (pre_last),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .smp_vbit (smp_vbit),
        .smp_ubit (smp_ubit),
        .smp_cbit (smp_cbit),
        .smp_ready(smp_ready),
        .word     (word)
    );

    bmc_line_enc #(
        .SAMPLE_W(SAMPLE_W)
    ) enc_i (
        .clk      (clk),
        .rst      (rst),
        .half_tick(half_tick),
        .half_idx (half_idx),
        .phase    (phase),
        .pre_kind (pre_kind),
        .word     (word),
        .line_out (line_out)
    );

endmodule

// File: rtl/bmc_tx_chk.sv
// Protocol checker bound to the transmitter top
module bmc_tx_chk
    import bmc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   half_tick,
    input logic   smp_valid,
    input logic   smp_ready,
    input logic   line_out,
    input phase_e phase,
    input logic   half_zero,
    input logic   half_lsb
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (!line_out && smp_ready));

    assert_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> $stable(line_out));

    assert_cell_edge_R3: assert property (@(posedge clk) disable iff (rst)
        (half_tick && phase != PH_PREAMBLE && !half_lsb) |=> (line_out != $past(line_out)));

    assert_pre_lead_R4: assert property (@(posedge clk) disable iff (rst)
        (half_tick && half_zero) |=> (line_out != $past(line_out)));

    assert_ready_window_R7: assert property (@(posedge clk) disable iff (rst)
        smp_ready |-> (phase == PH_PREAMBLE));

    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && smp_ready) |=> !smp_ready);

endmodule

bind bmc_tx bmc_tx_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .half_tick(half_tick),
    .smp_valid(smp_valid),
    .smp_ready(smp_ready),
    .line_out (line_out),
    .phase    (phase),
    .half_zero(half_zero),
    .half_lsb (half_lsb)
);

// File: tb/bmc_tx_tb_top.sv
module bmc_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BLK        = 192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        half_tick = 1'b0;
    logic        smp_valid = 1'b0;
    logic        smp_ready;
    logic [23:0] smp_data = '0;
    logic        smp_vbit = 1'b0;
    logic        smp_ubit = 1'b0;
    logic        smp_cbit = 1'b0;
    logic        line_out;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_sf   = 0;
    logic exp_line = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bmc_tx dut_i (
        .clk      (clk),
        .rst      (rst),
        .half_tick(half_tick),
        .smp_valid(smp_valid),
        .smp_ready(smp_ready),
        .smp_data (smp_data),
        .smp_vbit (smp_vbit),
        .smp_ubit (smp_ubit),
        .smp_cbit (smp_cbit),
        .line_out (line_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Expected inversion for preamble half-cell h (0..7); kind 0=A, 1=B, 2=block start
    function automatic logic pre_flip(input int kind, input int h);
        if (h == 0 || h == 3) return 1'b1;
        case (kind)
            2:       return (h == 4 || h == 5);
            1:       return (h == 5 || h == 6);
            default: return (h == 6 || h == 7);
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_line = 1'b0;
        exp_sf   = 0;
        chk("R1 line low after reset", 32'(line_out), 32'd0);
        chk("R1 ready high after reset", 32'(smp_ready), 32'd1);
    endtask

    // Emit one half-cell, then idle for gap cycles; starts and ends at a negedge
    task automatic half_step(input logic flip, input int gap, input string tag);
        half_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        half_tick = 1'b0;
        exp_line = exp_line ^ flip;
        chk(tag, 32'(line_out), 32'(exp_line));
        for (int g = 0; g < gap; g++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R2 line held between ticks", 32'(line_out), 32'(exp_line));
        end
    endtask

    task automatic run_subframe(input bit offer, input logic [23:0] d, input logic v,
                                input logic u, input logic c, input int late,
                                input bit extra, input int gap, input int stop_at,
                                input string tag);
        logic [27:0] w;
        int kind;
        w = offer ? {^{c, u, v, d}, c, u, v, d} : 28'd0;
        kind = (exp_sf == 0) ? 2 : ((exp_sf % 2 == 1) ? 1 : 0);
        for (int h = 0; h < stop_at; h++) begin
            if (offer && h == late) begin
                chk("R7 ready open in preamble", 32'(smp_ready), 32'd1);
                smp_valid = 1'b1;
                smp_data = d; smp_vbit = v; smp_ubit = u; smp_cbit = c;
                @(posedge clk);
                @(negedge clk);
                smp_valid = 1'b0;
                chk("R9 ready drops after transfer", 32'(smp_ready), 32'd0);
                if (extra) begin
                    smp_valid = 1'b1;
                    smp_data = ~d; smp_vbit = ~v; smp_ubit = ~u; smp_cbit = ~c;
                    @(posedge clk);
                    @(negedge clk);
                    smp_valid = 1'b0;
                    chk("R9 ready stays low", 32'(smp_ready), 32'd0);
                end
            end
            if (h < 8) begin
                half_step(pre_flip(kind, h), gap, "R4 R6 preamble level");
            end else if (h % 2 == 0) begin
                half_step(1'b1, gap, "R3 cell start level");
            end else begin
                half_step(w[h / 2 - 4], gap, tag);
            end
            if (h == 7 && !offer) chk("R7 window closes after half 7", 32'(smp_ready), 32'd0);
            if (h == 63) chk("R7 window reopens at subframe end", 32'(smp_ready), 32'd1);
        end
        if (stop_at == 64) exp_sf = (exp_sf == BLK - 1) ? 0 : exp_sf + 1;
    endtask

    task automatic t_reset();
        do_reset();
    endtask

    task automatic t_samples();
        run_subframe(1, 24'h000001, 1'b0, 1'b0, 1'b0, 0, 0, 0, 64, "R3 R5 sample LSB");
        run_subframe(1, 24'h800000, 1'b1, 1'b0, 1'b1, 2, 0, 0, 64, "R3 R5 sample MSB");
        run_subframe(1, 24'hA5C3F0, 1'b0, 1'b1, 1'b0, 4, 0, 0, 64, "R3 R5 mixed pattern");
        run_subframe(1, 24'hFFFFFF, 1'b1, 1'b1, 1'b1, 1, 0, 0, 64, "R3 R5 all ones");
    endtask

    task automatic t_no_sample();
        run_subframe(0, 24'h0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 64, "R8 zero payload");
    endtask

    task automatic t_late_take();
        run_subframe(1, 24'h123456, 1'b0, 1'b0, 1'b1, 7, 0, 0, 64, "R7 R5 late transfer payload");
    endtask

    task automatic t_ignored_valid();
        run_subframe(1, 24'h0F0F0F, 1'b1, 1'b0, 1'b0, 3, 1, 0, 64, "R9 second offer ignored");
    endtask

    task automatic t_gaps();
        run_subframe(1, 24'h5A5A5A, 1'b0, 1'b1, 1'b1, 0, 0, 3, 64, "R2 R5 payload with gaps");
    endtask

    task automatic t_block_wrap();
        while (exp_sf != 0) begin
            run_subframe(0, 24'h0, 1'b0, 1'b0, 1'b0, 0, 0, 0, 64, "R6 R8 idle subframe");
        end
        run_subframe(1, 24'h00FF00, 1'b0, 1'b0, 1'b0, 0, 0, 0, 64, "R6 block restart payload");
    endtask

    task automatic t_reset_mid();
        run_subframe(1, 24'h777777, 1'b1, 1'b1, 1'b0, 0, 0, 0, 64, "R3 R5 before reset");
        run_subframe(1, 24'h333333, 1'b0, 1'b0, 1'b0, 0, 0, 0, 30, "R3 R5 partial");
        do_reset();
        run_subframe(1, 24'hC0FFEE, 1'b0, 1'b1, 1'b0, 0, 0, 0, 64, "R1 R5 after mid reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_samples();
        t_no_sample();
        t_late_take();
        t_ignored_valid();
        t_gaps();
        t_block_wrap();
        t_reset_mid();
        summary();
        $finish;
    end

endmodule